// File: doc/BRIEF.md
# Banked Fault Capture Registers

This block keeps the two fault-reporting registers of a system control coprocessor: a fault address register, which holds the modified virtual address of the last precise fault, and an instruction fault status register, which holds the status of the last prefetch fault. There are two copies of each register. One belongs to the Secure world and the other to the Non-secure world. The `world_secure` input picks the copy that a software access or a world-relative hardware capture uses.

The block decodes coprocessor register-transfer requests: an opcode field pair, two register-number fields, a direction, write data, the privilege level and the world. A privileged request that hits one of the two encodings reads or writes the copy of the current world. A User-mode request to either encoding is refused with a single-cycle undefined-instruction flag. A request that hits neither encoding is flagged as unmatched, so that other coprocessor logic can claim it.

Hardware capture paths load the registers directly:
- A precise abort or a watchpoint debug entry loads the fault address register.
- A prefetch abort loads the fault status register.
- A monitor entry caused by an external abort, while external aborts are routed to the monitor, loads the Secure status copy.

Top module: `fault_capture_regs`

## Requirements
- R1: After reset, all four register copies read as zero, and `rsp_valid` and `rsp_rdata` are zero.
- R2: A privileged request with op1=0, crn=6, crm=0, op2=0 reaches the fault address register, which is DATA_W bits wide. A write stores `req_wdata` unchanged into the copy selected by `world_secure` (1 = Secure). A read returns that copy.
- R3: A privileged request with op1=0, crn=5, crm=0, op2=1 reaches the fault status copy of the current world. A write stores the low IFSR_W bits of the data. A read returns them zero-extended to DATA_W.
- R4: A request with `req_priv`=0 that hits either encoding raises `rsp_undef` in the same cycle as the request. It leaves every copy unchanged, and its response data is zero.
- R5: A request that hits neither encoding raises `rsp_unmatched` in the same cycle, whatever its privilege, and never raises `rsp_undef`. It changes no copy, and its response data is zero.
- R6: `pa_valid` loads `pa_addr` into the fault address copy of the current world.
- R7: `wp_valid` loads `wp_addr` into the fault address copy of the current world. When `pa_valid` is also high, the abort address wins.
- R8: `pf_valid` loads `pf_status` into the fault status copy of the current world.
- R9: `mon_ea_valid` with `ea_to_monitor`=1 loads `mon_ea_status` into the Secure fault status copy, whatever the world. In the same cycle it wins over a Secure prefetch capture. With `ea_to_monitor`=0 it has no effect.
- R10: When a hardware capture and a software write target the same copy in the same cycle, the copy takes the captured value. A capture into one copy does not block a software write into the other copy.
- R11: `rsp_valid` follows `req_valid` by one cycle. `rsp_rdata` carries the value of the copy as it was before any update in the request cycle. It is zero for writes, refused requests and unmatched requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register-transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_op2 | input | 3 | Second opcode field |
| req_wdata | input | DATA_W | Write data |
| req_priv | input | 1 | 1 = privileged mode, 0 = User mode |
| world_secure | input | 1 | Current world, 1 = Secure |
| pa_valid | input | 1 | Precise abort capture strobe |
| pa_addr | input | DATA_W | Faulting address of the precise abort |
| wp_valid | input | 1 | Watchpoint debug-entry capture strobe |
| wp_addr | input | DATA_W | Watchpoint fault address |
| pf_valid | input | 1 | Prefetch abort capture strobe |
| pf_status | input | IFSR_W | Prefetch abort status |
| mon_ea_valid | input | 1 | Monitor entry caused by an external abort |
| mon_ea_status | input | IFSR_W | Status written on that monitor entry |
| ea_to_monitor | input | 1 | External aborts routed to the monitor |
| rsp_undef | output | 1 | Undefined-instruction pulse, same cycle as the request |
| rsp_unmatched | output | 1 | Request hit neither encoding, same cycle |
| rsp_valid | output | 1 | Response data valid |
| rsp_rdata | output | DATA_W | Read data |

## Verification
A wrong internal state in this block has two typical forms. In the first, a copy is updated from the wrong world or by a refused access. In the second, a capture loses to a software write. Either fault stays hidden until a privileged read of that copy, and it then shows as a wrong `rsp_rdata` one cycle after the read request. For this reason the bench follows every disturbing stimulus with reads of both copies of the affected register. A decode fault shows sooner: `rsp_undef` or `rsp_unmatched` is wrong in the request cycle itself.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int OP1_W = 3;
  localparam int CRN_W = 4;
  localparam int CRM_W = 4;
  localparam int OP2_W = 3;

  typedef struct packed {
    logic [OP1_W-1:0] op1;
    logic [CRN_W-1:0] crn;
    logic [CRM_W-1:0] crm;
    logic [OP2_W-1:0] op2;
  } cp_sel_t;

  localparam cp_sel_t SEL_FADDR = '{op1: 3'd0, crn: 4'd6, crm: 4'd0, op2: 3'd0};
  localparam cp_sel_t SEL_FSTAT = '{op1: 3'd0, crn: 4'd5, crm: 4'd0, op2: 3'd1};

  localparam int WORLDS = 2;
  localparam int IDX_NS = 0;
  localparam int IDX_S  = 1;
endpackage

// File: rtl/fcr_decode.sv
module fcr_decode
  import fcr_pkg::*;
(
  input  logic    req_valid,
  input  logic    req_write,
  input  cp_sel_t sel,
  input  logic    req_priv,
  output logic    hit_faddr,
  output logic    hit_fstat,
  output logic    undef,
  output logic    unmatched,
  output logic    wr_faddr,
  output logic    wr_fstat,
  output logic    rd_faddr,
  output logic    rd_fstat
);
  logic any_hit;

  always_comb begin
    hit_faddr = req_valid && (sel == SEL_FADDR);
    hit_fstat = req_valid && (sel == SEL_FSTAT);
    any_hit   = hit_faddr || hit_fstat;
    undef     = any_hit && !req_priv;
    unmatched = req_valid && !any_hit;
    wr_faddr  = hit_faddr && req_priv && req_write;
    wr_fstat  = hit_fstat && req_priv && req_write;
    rd_faddr  = hit_faddr && req_priv && !req_write;
    rd_fstat  = hit_fstat && req_priv && !req_write;
  end
endmodule

// File: rtl/fcr_bank.sv
module fcr_bank #(
  parameter int W      = 32,
  parameter int COPIES = 2,
  parameter int IDX_W  = (COPIES > 1) ? $clog2(COPIES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sw_we,
  input  logic [IDX_W-1:0]           sw_idx,
  input  logic [W-1:0]               sw_data,
  input  logic [COPIES-1:0]          hw_we,
  input  logic [COPIES-1:0][W-1:0]   hw_data,
  output logic [COPIES-1:0][W-1:0]   q
);
  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    logic sw_hit;
    assign sw_hit = sw_we && (sw_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)            q[i] <= '0;
      else if (hw_we[i])  q[i] <= hw_data[i];
      else if (sw_hit)    q[i] <= sw_data;
    end

    // R1: copy is clear on the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> q[i] == '0);
    // R10: hardware capture value lands regardless of a software write
    a_r10_hw_wins: assert property (@(posedge clk) disable iff (rst)
      hw_we[i] |=> q[i] == $past(hw_data[i]));
    // R2: software write stores data unchanged when no capture competes
    a_r2_sw_store: assert property (@(posedge clk) disable iff (rst)
      (sw_hit && !hw_we[i]) |=> q[i] == $past(sw_data));
  end
endmodule

// File: rtl/fault_capture_regs.sv
module fault_capture_regs
  import fcr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IFSR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_priv,
  input  logic              world_secure,
  input  logic              pa_valid,
  input  logic [DATA_W-1:0] pa_addr,
  input  logic              wp_valid,
  input  logic [DATA_W-1:0] wp_addr,
  input  logic              pf_valid,
  input  logic [IFSR_W-1:0] pf_status,
  input  logic              mon_ea_valid,
  input  logic [IFSR_W-1:0] mon_ea_status,
  input  logic              ea_to_monitor,
  output logic              rsp_undef,
  output logic              rsp_unmatched,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int PAD_W = DATA_W - IFSR_W;

  cp_sel_t sel;
  logic hit_faddr, hit_fstat, wr_faddr, wr_fstat, rd_faddr, rd_fstat;

  assign sel = '{op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};

  fcr_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .sel       (sel),
    .req_priv  (req_priv),
    .hit_faddr (hit_faddr),
    .hit_fstat (hit_fstat),
    .undef     (rsp_undef),
    .unmatched (rsp_unmatched),
    .wr_faddr  (wr_faddr),
    .wr_fstat  (wr_fstat),
    .rd_faddr  (rd_faddr),
    .rd_fstat  (rd_fstat)
  );

  // Capture steering: abort address has priority over watchpoint address;
  // a routed monitor entry has priority on the Secure status copy.
  logic                            cap_faddr, mon_fire;
  logic [DATA_W-1:0]               cap_addr;
  logic [WORLDS-1:0]               fa_hw_we, fs_hw_we;
  logic [WORLDS-1:0][DATA_W-1:0]   fa_hw_data, fa_q;
  logic [WORLDS-1:0][IFSR_W-1:0]   fs_hw_data, fs_q;

  always_comb begin
    cap_faddr        = pa_valid || wp_valid;
    cap_addr         = pa_valid ? pa_addr : wp_addr;
    mon_fire         = mon_ea_valid && ea_to_monitor;
    fa_hw_we[IDX_S]  = cap_faddr && world_secure;
    fa_hw_we[IDX_NS] = cap_faddr && !world_secure;
    fa_hw_data[IDX_S]  = cap_addr;
    fa_hw_data[IDX_NS] = cap_addr;
    fs_hw_we[IDX_S]  = mon_fire || (pf_valid && world_secure);
    fs_hw_we[IDX_NS] = pf_valid && !world_secure;
    fs_hw_data[IDX_S]  = mon_fire ? mon_ea_status : pf_status;
    fs_hw_data[IDX_NS] = pf_status;
  end

  fcr_bank #(.W(DATA_W), .COPIES(WORLDS)) u_faddr (
    .clk     (clk),
    .rst     (rst),
    .sw_we   (wr_faddr),
    .sw_idx  (world_secure),
    .sw_data (req_wdata),
    .hw_we   (fa_hw_we),
    .hw_data (fa_hw_data),
    .q       (fa_q)
  );

  fcr_bank #(.W(IFSR_W), .COPIES(WORLDS)) u_fstat (
    .clk     (clk),
    .rst     (rst),
    .sw_we   (wr_fstat),
    .sw_idx  (world_secure),
    .sw_data (req_wdata[IFSR_W-1:0]),
    .hw_we   (fs_hw_we),
    .hw_data (fs_hw_data),
    .q       (fs_q)
  );

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    if (rd_faddr)      rd_next = fa_q[world_secure];
    else if (rd_fstat) rd_next = {{PAD_W{1'b0}}, fs_q[world_secure]};
    else               rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_next;
    end
  end

  // R11: response one cycle after request
  a_r11_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rsp_valid == $past(req_valid));
  // R11: refused, unmatched and write responses carry zero
  a_r11_zero_data: assert property (@(posedge clk) disable iff (rst)
    $past(rsp_undef || rsp_unmatched || (req_valid && req_write)) |-> rsp_rdata == '0);
  // R5: unmatched and undefined never coincide
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rsp_undef && rsp_unmatched));
  // R4: refused access leaves the address copies alone
  a_r4_refused_hold_fa: assert property (@(posedge clk) disable iff (rst)
    (rsp_undef && !pa_valid && !wp_valid) |=> $stable(fa_q));
  // R4: refused access leaves the status copies alone
  a_r4_refused_hold_fs: assert property (@(posedge clk) disable iff (rst)
    (rsp_undef && !pf_valid && !mon_fire) |=> $stable(fs_q));
  // R5: unmatched access leaves the address copies alone
  a_r5_unmatched_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_unmatched && !pa_valid && !wp_valid) |=> $stable(fa_q));
  // R7: abort address beats watchpoint address in the Secure copy
  a_r7_abort_first_s: assert property (@(posedge clk) disable iff (rst)
    (pa_valid && world_secure) |=> fa_q[IDX_S] == $past(pa_addr));
  // R9: routed monitor entry always lands in the Secure status copy
  a_r9_monitor_secure: assert property (@(posedge clk) disable iff (rst)
    mon_fire |=> fs_q[IDX_S] == $past(mon_ea_status));
endmodule

// File: tb/fault_capture_regs_tb.sv
module fault_capture_regs_tb_top;
  localparam int DW = 32;
  localparam int IW = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic req_valid, req_write, req_priv, world_secure;
  logic [2:0] req_op1, req_op2;
  logic [3:0] req_crn, req_crm;
  logic [DW-1:0] req_wdata, pa_addr, wp_addr;
  logic pa_valid, wp_valid, pf_valid, mon_ea_valid, ea_to_monitor;
  logic [IW-1:0] pf_status, mon_ea_status;
  logic rsp_undef, rsp_unmatched, rsp_valid;
  logic [DW-1:0] rsp_rdata;

  fault_capture_regs #(.DATA_W(DW), .IFSR_W(IW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
    .req_wdata(req_wdata), .req_priv(req_priv), .world_secure(world_secure),
    .pa_valid(pa_valid), .pa_addr(pa_addr), .wp_valid(wp_valid), .wp_addr(wp_addr),
    .pf_valid(pf_valid), .pf_status(pf_status),
    .mon_ea_valid(mon_ea_valid), .mon_ea_status(mon_ea_status), .ea_to_monitor(ea_to_monitor),
    .rsp_undef(rsp_undef), .rsp_unmatched(rsp_unmatched),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic [DW-1:0] fa_m[2];
  logic [IW-1:0] fs_m[2];

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic clear_inputs();
    req_valid = 0; req_write = 0; req_priv = 1; world_secure = 0;
    req_op1 = 0; req_crn = 0; req_crm = 0; req_op2 = 0; req_wdata = '0;
    pa_valid = 0; pa_addr = '0; wp_valid = 0; wp_addr = '0;
    pf_valid = 0; pf_status = '0; mon_ea_valid = 0; mon_ea_status = '0;
    ea_to_monitor = 0;
  endtask

  // kind: 0 address reg, 1 status reg, 2 and 3 foreign encodings
  task automatic set_req(int kind, bit wr, logic [DW-1:0] wd, bit pr, bit sc);
    req_valid = 1; req_write = wr; req_wdata = wd; req_priv = pr; world_secure = sc;
    case (kind)
      0: begin req_op1 = 0; req_crn = 6; req_crm = 0; req_op2 = 0; end
      1: begin req_op1 = 0; req_crn = 5; req_crm = 0; req_op2 = 1; end
      2: begin req_op1 = 0; req_crn = 6; req_crm = 0; req_op2 = 1; end
      default: begin req_op1 = 1; req_crn = 5; req_crm = 0; req_op2 = 1; end
    endcase
  endtask

  // Evaluate one cycle of stimulus already on the pins (called at a negedge).
  task automatic step(string tag);
    int s;
    bit fh, sh;
    logic [DW-1:0] erd;
    s  = world_secure ? 1 : 0;
    fh = req_op1 == 0 && req_crn == 6 && req_crm == 0 && req_op2 == 0;
    sh = req_op1 == 0 && req_crn == 5 && req_crm == 0 && req_op2 == 1;
    erd = '0;
    if (req_valid && !req_write && req_priv)
      erd = fh ? fa_m[s] : (sh ? DW'(fs_m[s]) : '0);
    #1;
    chk({tag, " undef"}, DW'(rsp_undef), DW'(req_valid && (fh || sh) && !req_priv));
    chk({tag, " unmatched"}, DW'(rsp_unmatched), DW'(req_valid && !fh && !sh));
    if (req_valid) begin
      exp_q.push_back(erd);
      tag_q.push_back({tag, " rdata"});
    end
    if (req_valid && req_write && req_priv && fh) fa_m[s] = req_wdata;
    if (req_valid && req_write && req_priv && sh) fs_m[s] = req_wdata[IW-1:0];
    if (pa_valid) fa_m[s] = pa_addr;
    else if (wp_valid) fa_m[s] = wp_addr;
    if (pf_valid) fs_m[s] = pf_status;
    if (mon_ea_valid && ea_to_monitor) fs_m[1] = mon_ea_status;
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic read_all(string tag);
    for (int k = 0; k < 4; k++) begin
      set_req(k / 2, 0, '0, 1, k[0]);
      step(tag);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin fa_m[k] = '0; fs_m[k] = '0; end
    clear_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 rsp_valid", DW'(rsp_valid), '0);
    chk("R1 rsp_rdata", rsp_rdata, '0);
    read_all("R1");

    // R2 banked address register
    set_req(0, 1, 32'hDEAD_BEEF, 1, 1); step("R2");
    set_req(0, 1, 32'h1234_5678, 1, 0); step("R2");
    read_all("R2");

    // R3 status register, upper bits dropped
    set_req(1, 1, 32'hFFFF_A5A5, 1, 1); step("R3");
    set_req(1, 1, 32'h0000_0123, 1, 0); step("R3");
    read_all("R3");

    // R4 User-mode access refused
    set_req(0, 1, 32'h0BAD_0BAD, 0, 1); step("R4");
    set_req(1, 1, 32'h0000_1FFF, 0, 0); step("R4");
    set_req(0, 0, '0, 0, 0); step("R4");
    read_all("R4");

    // R5 foreign encodings
    set_req(2, 1, 32'h5555_AAAA, 1, 1); step("R5");
    set_req(3, 1, 32'h0000_0777, 1, 0); step("R5");
    set_req(2, 0, '0, 0, 0); step("R5");
    read_all("R5");

    // R6 precise abort capture in each world
    pa_valid = 1; pa_addr = 32'hA000_0010; world_secure = 0; step("R6");
    pa_valid = 1; pa_addr = 32'hA000_0020; world_secure = 1; step("R6");
    read_all("R6");

    // R7 watchpoint capture, and abort wins over watchpoint
    wp_valid = 1; wp_addr = 32'hB000_0004; world_secure = 0; step("R7");
    pa_valid = 1; pa_addr = 32'hC000_0008; wp_valid = 1; wp_addr = 32'hB000_000C;
    world_secure = 1; step("R7");
    read_all("R7");

    // R8 prefetch abort capture
    pf_valid = 1; pf_status = 13'h0406; world_secure = 0; step("R8");
    pf_valid = 1; pf_status = 13'h0008; world_secure = 1; step("R8");
    read_all("R8");

    // R9 monitor entry: routed, not routed, and beating a Secure prefetch
    mon_ea_valid = 1; mon_ea_status = 13'h1008; ea_to_monitor = 1; world_secure = 0; step("R9");
    read_all("R9");
    mon_ea_valid = 1; mon_ea_status = 13'h0777; ea_to_monitor = 0; world_secure = 1; step("R9");
    read_all("R9");
    mon_ea_valid = 1; mon_ea_status = 13'h0016; ea_to_monitor = 1;
    pf_valid = 1; pf_status = 13'h0005; world_secure = 1; step("R9");
    read_all("R9");

    // R10 capture beats software write on the same copy
    set_req(0, 1, 32'h1111_1111, 1, 1); pa_valid = 1; pa_addr = 32'hE000_0001; step("R10");
    set_req(1, 1, 32'h0000_0ABC, 1, 0); pf_valid = 1; pf_status = 13'h0002; step("R10");
    // capture into the other copy does not block the write
    set_req(1, 1, 32'h0000_0333, 1, 0); mon_ea_valid = 1; ea_to_monitor = 1;
    mon_ea_status = 13'h0444; step("R10");
    read_all("R10");

    // R11 read during capture returns the old value; back-to-back requests
    set_req(0, 0, '0, 1, 0); wp_valid = 1; wp_addr = 32'hF00D_F00D; step("R11");
    set_req(0, 0, '0, 1, 0); step("R11");
    set_req(1, 0, '0, 1, 1); step("R11");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule